// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Controller

This block sits at the decode stage of an in-order, two-wide pipeline. Every cycle it looks at the two oldest pre-decoded instructions in the queue: slot 0 is the older one and slot 1 the younger one. It then decides whether zero, one or both of them issue. Each instruction carries a three-bit group tag. The block pairs two instructions only when they do not compete for a structural resource. When the pair is illegal, the older instruction issues alone and the younger one is held for a later cycle.

Serializing instructions in the CO group issue alone. A CO instruction can also carry a lock length, which keeps the decode stage closed for several cycles after it issues. A two-state machine handles this. In the state OPEN, issue follows the pairing rules. In the state LOCKED, a down-counter runs and both issue flags are held low. There are two transitions. OPEN goes to LOCKED when a CO instruction with a lock length of two or more issues from slot 0. LOCKED goes back to OPEN when the counter steps from one to zero. A synchronous reset forces OPEN from either state.

The queue uses the issue flags to decide how far to advance. Opcode decoding, operand dependency checks and floating-point stage tracking live in other blocks.

Top module: `pair_issue_ctrl`

## Requirements
- R1: Group tags are encoded as MT=0, EX=1, LS=2, BR=3, FE=4 and CO=5.
- R2: When the block is not locked, slot 0 issues exactly when `s0_valid` is high. At most two instructions issue per cycle.
- R3: Slot 1 never issues unless slot 0 issues in the same cycle. This holds in particular when `s0_valid` is low.
- R4: A CO instruction issues without a partner. If either slot holds a CO tag, slot 1 does not issue.
- R5: Two EX instructions never issue together.
- R6: Two BR instructions never issue together.
- R7: Two LS instructions never issue together.
- R8: Two FE instructions never issue together.
- R9: Apart from R4 to R8, any pair issues together. This includes MT with any non-CO group, MT with MT, and any two different non-CO groups.
- R10: The reserved tags 6 and 7 are handled exactly like CO, including the lock length.
- R11: Suppose a CO instruction with lock length L of at least 2 issues from slot 0 in cycle t. Then both issue flags stay low in cycles t+1 to t+L-1, and issue resumes in cycle t+L. A lock length of 0 or 1 adds no stall.
- R12: While the block is locked, the slot inputs are ignored. A CO instruction presented during a lock does not issue and does not extend or restart the lock.
- R13: `s1_stall` is high exactly when `s1_valid` is high and slot 1 does not issue.
- R14: A synchronous reset returns the block to OPEN with the counter cleared. Issue is possible in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Slot 0 (older) instruction present |
| s0_group | input | 3 | Slot 0 group tag |
| s0_lock | input | LOCK_W | Slot 0 decode-lock length in cycles, counting the issue cycle |
| s1_valid | input | 1 | Slot 1 (younger) instruction present |
| s1_group | input | 3 | Slot 1 group tag |
| s0_issue | output | 1 | Slot 0 issues this cycle |
| s1_issue | output | 1 | Slot 1 issues this cycle |
| s1_stall | output | 1 | Slot 1 is valid but held |

## Verification
The bench aims at the cycles on either side of a lock. A counter that is off by one would release issue a cycle early or a cycle late after a lock length of 2, 5 or 16. A lock length of 1 has to add no stall at all, and a design that treats it as one locked cycle would drop a cycle of issue. A CO instruction presented while the block is locked must not restart the counter; a design that reloads it would stretch the stall. A reset in the middle of a lock must reopen issue at once. The bench also presents same-group pairs, CO and reserved tags in either slot, and an empty slot 0 beside a valid slot 1. A design that gets these wrong would dual-issue a contended pair or issue out of order.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

    typedef enum logic [2:0] {
        GRP_MT = 3'd0,
        GRP_EX = 3'd1,
        GRP_LS = 3'd2,
        GRP_BR = 3'd3,
        GRP_FE = 3'd4,
        GRP_CO = 3'd5
    } grp_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_st_e;

    // CO and both reserved codes must issue alone
    function automatic logic grp_solo(input logic [2:0] g);
        return g >= 3'(GRP_CO);
    endfunction

endpackage

// File: rtl/pair_rules.sv
module pair_rules
    import pair_issue_pkg::*;
(
    input  logic [2:0] g_old,
    input  logic [2:0] g_young,
    output logic       pair_ok
);
    // groups that own a single shared resource: EX, LS, BR, FE
    localparam int FIRST_SHARED = 1;
    localparam int LAST_SHARED  = 4;

    logic [LAST_SHARED:FIRST_SHARED] clash;

    genvar gi;
    generate
        for (gi = FIRST_SHARED; gi <= LAST_SHARED; gi++) begin : g_clash
            assign clash[gi] = (g_old == 3'(gi)) && (g_young == 3'(gi));
        end
    endgenerate

    always_comb begin
        pair_ok = !grp_solo(g_old) && !grp_solo(g_young) && (clash == '0);
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import pair_issue_pkg::*;
#(
    parameter int LOCK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LOCK_W-1:0] len,
    output logic              open_o
);
    localparam logic [LOCK_W-1:0] ONE = LOCK_W'(1);

    lock_st_e          state, state_n;
    logic [LOCK_W-1:0] cnt, cnt_n;

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_OPEN: begin
                if (start && (len > ONE)) begin
                    state_n = ST_LOCKED;
                    cnt_n   = len - ONE;
                end
            end
            ST_LOCKED: begin
                cnt_n = cnt - ONE;
                if (cnt == ONE) state_n = ST_OPEN;
            end
            default: begin
                state_n = ST_OPEN;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPEN;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        open_o = (state == ST_OPEN);
    end

    // R11
    lock_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED && cnt > ONE) |=> (state == ST_LOCKED));

    // R11
    lock_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPEN && start && len > ONE) |=> (state == ST_LOCKED));

endmodule

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
    import pair_issue_pkg::*;
#(
    parameter int LOCK_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s0_valid,
    input  logic [2:0]        s0_group,
    input  logic [LOCK_W-1:0] s0_lock,
    input  logic              s1_valid,
    input  logic [2:0]        s1_group,
    output logic              s0_issue,
    output logic              s1_issue,
    output logic              s1_stall
);
    logic pair_ok;
    logic dec_open;
    logic co_go;

    pair_rules u_rules (
        .g_old   (s0_group),
        .g_young (s1_group),
        .pair_ok (pair_ok)
    );

    lock_fsm #(.LOCK_W(LOCK_W)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .start  (co_go),
        .len    (s0_lock),
        .open_o (dec_open)
    );

    always_comb begin
        s0_issue = dec_open && s0_valid;
        s1_issue = s0_issue && s1_valid && pair_ok;
        s1_stall = s1_valid && !s1_issue;
        co_go    = s0_issue && grp_solo(s0_group);
    end

    // R3
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        s1_issue |-> s0_issue);

    // R4
    co_alone_chk: assert property (@(posedge clk) disable iff (rst)
        s1_issue |-> (s0_group < 3'(GRP_CO) && s1_group < 3'(GRP_CO)));

    // R5
    same_group_chk: assert property (@(posedge clk) disable iff (rst)
        s1_issue |-> (s0_group != s1_group || s0_group == 3'(GRP_MT)));

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s0_issue && s0_group >= 3'(GRP_CO) && s0_lock > LOCK_W'(1))
            |=> (!s0_issue && !s1_issue));

    // R13
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        s1_stall |-> (s1_valid && !s1_issue));

endmodule

// File: tb/pair_issue_ctrl_test.sv
module pair_issue_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int LOCK_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s0_valid = 1'b0;
    logic [2:0]        s0_group = '0;
    logic [LOCK_W-1:0] s0_lock = '0;
    logic              s1_valid = 1'b0;
    logic [2:0]        s1_group = '0;
    logic              s0_issue, s1_issue, s1_stall;

    int n_chk  = 0;
    int n_fail = 0;
    int lockc  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pair_issue_ctrl #(.LOCK_W(LOCK_W)) uut (
        .clk(clk), .rst(rst),
        .s0_valid(s0_valid), .s0_group(s0_group), .s0_lock(s0_lock),
        .s1_valid(s1_valid), .s1_group(s1_group),
        .s0_issue(s0_issue), .s1_issue(s1_issue), .s1_stall(s1_stall)
    );

    function automatic bit solo_f(input bit [2:0] g);
        return g >= 3'd5;
    endfunction

    function automatic bit pair_f(input bit [2:0] a, input bit [2:0] b);
        return !solo_f(a) && !solo_f(b) && (a == 3'd0 || b == 3'd0 || a != b);
    endfunction

    task automatic chk(input string req, input string what, input bit act, input bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input bit r,
                        input bit v0, input bit [2:0] g0, input bit [LOCK_W-1:0] l0,
                        input bit v1, input bit [2:0] g1);
        bit e0, e1, es;
        @(negedge clk);
        rst = r; s0_valid = v0; s0_group = g0; s0_lock = l0;
        s1_valid = v1; s1_group = g1;
        #1;
        e0 = (lockc == 0) && v0;
        e1 = e0 && v1 && pair_f(g0, g1);
        es = v1 && !e1;
        chk(req, "s0_issue", s0_issue, e0);
        chk(req, "s1_issue", s1_issue, e1);
        chk({req, " R13"}, "s1_stall", s1_stall, es);
        if (r) lockc = 0;
        else if (lockc > 0) lockc--;
        else if (e0 && solo_f(g0) && l0 > 1) lockc = int'(l0) - 1;
    endtask

    task automatic idle_run(input string req, input int n);
        for (int i = 0; i < n; i++) step(req, 0, 1, 3'd0, 0, 1, 3'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state: outputs follow inputs under reset with lock cleared
        step("R1 reset", 1, 1, 3'd5, 20, 1, 3'd0);
        step("R14 first cycle after reset", 0, 1, 3'd0, 0, 1, 3'd0);
        step("R9 MT+MT", 0, 1, 3'd0, 0, 1, 3'd0);
        step("R5 EX+EX", 0, 1, 3'd1, 0, 1, 3'd1);
        step("R6 BR+BR", 0, 1, 3'd3, 0, 1, 3'd3);
        step("R7 LS+LS", 0, 1, 3'd2, 0, 1, 3'd2);
        step("R8 FE+FE", 0, 1, 3'd4, 0, 1, 3'd4);
        step("R9 EX+LS", 0, 1, 3'd1, 0, 1, 3'd2);
        step("R9 FE+MT", 0, 1, 3'd4, 0, 1, 3'd0);
        step("R9 BR+FE", 0, 1, 3'd3, 0, 1, 3'd4);
        step("R4 MT+CO", 0, 1, 3'd0, 0, 1, 3'd5);
        step("R4 CO lock0 +MT", 0, 1, 3'd5, 0, 1, 3'd0);
        step("R10 tag6 +MT", 0, 1, 3'd6, 0, 1, 3'd0);
        step("R10 MT+tag7", 0, 1, 3'd0, 0, 1, 3'd7);
        step("R3 slot0 empty", 0, 0, 3'd0, 0, 1, 3'd0);
        step("R2 slot0 alone", 0, 1, 3'd1, 0, 0, 3'd1);
        step("R11 lock1 no stall", 0, 1, 3'd5, 1, 0, 3'd0);
        step("R11 after lock1", 0, 1, 3'd0, 0, 1, 3'd1);
        step("R11 lock5 issue", 0, 1, 3'd5, 5, 1, 3'd0);
        idle_run("R11 lock5 window", 5);
        step("R11 lock2 issue", 0, 1, 3'd5, 2, 0, 3'd0);
        idle_run("R11 lock2 window", 2);
        step("R11 lock16 issue", 0, 1, 3'd5, 16, 0, 3'd0);
        idle_run("R11 lock16 window", 16);
        step("R10 tag7 lock4", 0, 1, 3'd7, 4, 1, 3'd0);
        idle_run("R10 tag7 window", 4);
        step("R12 lock6 issue", 0, 1, 3'd5, 6, 0, 3'd0);
        step("R12 CO during lock", 0, 1, 3'd5, 20, 1, 3'd0);
        step("R12 CO during lock", 0, 1, 3'd5, 20, 0, 3'd0);
        idle_run("R12 lock not restarted", 5);
        step("R14 lock20 issue", 0, 1, 3'd5, 20, 0, 3'd0);
        idle_run("R14 locked", 2);
        step("R14 reset mid-lock", 1, 1, 3'd0, 0, 1, 3'd0);
        step("R14 open after reset", 0, 1, 3'd1, 0, 1, 3'd0);
        // R2 R9 constrained random
        for (int i = 0; i < 3000; i++) begin
            bit [2:0] ga, gb;
            bit [LOCK_W-1:0] la;
            ga = 3'($urandom % 8);
            gb = 3'($urandom % 8);
            la = (($urandom % 6) == 0) ? LOCK_W'($urandom % 18) : LOCK_W'($urandom % 3);
            step("R2 random", 0, ($urandom % 8) != 0, ga, la, ($urandom % 4) != 0, gb);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule